// File: doc/BRIEF.md
# Camera 4:2:2 Pixel Capture with Window Clip

This block sits directly behind a camera's 8-bit progressive byte stream. The stream carries 4:2:2 video. It regroups the bytes into whole pixels that hold Y, Cb and Cr in parallel, at one pixel for every two bytes. It tracks the current column and line from the two sync inputs. It forwards only the pixels inside a rectangle set by four bound inputs.

A source-select input swaps the camera samples for a built-in pattern of vertical colour bars. The pattern runs on the same counters and through the same window, so a downstream frame writer sees identical timing from either source.

Each forwarded pixel comes with a valid strobe. Two markers ride with it: one flags the first pixel of each clipped line, and one flags the last pixel of the clipped frame.

Top module: `yc422_window`

## Requirements
- R1: While `rst_n` is low, `pix_vld`, `line_start` and `frame_end` are 0.
- R2: A byte is active while `cam_hs` is 1. The first active byte after `cam_hs` rises is Cb, and the group repeats in the order Cb, Y1, Cr, Y2. A pixel is output one clock after its Cr byte (Y1 pixel) and one clock after its Y2 byte (Y2 pixel). Valid outputs therefore never run for more than two clocks in a row.
- R3: Both pixels of a group carry that group's single Cb and Cr byte. The first pixel carries Y1 and the second carries Y2.
- R4: The column count of the Y1 pixel of group g is 2g, and that of the Y2 pixel is 2g+1. It restarts at 0 on each line. The line count is 0 for the first line after `cam_vs` was high, and it rises by one at each falling edge of `cam_hs`.
- R5: A pixel is output only when col_lo <= column <= col_hi and row_lo <= line <= row_hi. All four bounds are inclusive.
- R6: `src_bars` = 0 outputs camera samples. `src_bars` = 1 outputs colour-bar samples with the same timing.
- R7: The colour bar is chosen by column bits [10:7]. Codes 0 to 9 give, as (Y,Cb,Cr): white (235,128,128), yellow (210,16,146), cyan (170,166,16), green (145,54,34), magenta (106,202,222), red (81,90,240), blue (41,240,110), black (16,128,128), white, yellow. Codes 10 to 15 give cyan.
- R8: `line_start` is 1 together with a valid pixel whose column equals col_lo. It is 0 at all other times.
- R9: `frame_end` is 1 together with the valid pixel at column col_hi on line row_hi. It is 0 at all other times.
- R10: Colour bars use the same column and line counters and the same window as the camera path.
- R11: Bytes presented while `cam_hs` is 0 produce no pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cam_byte | input | DW | Camera byte |
| cam_hs | input | 1 | High during the active bytes of a line |
| cam_vs | input | 1 | High during vertical blanking; clears the line count |
| src_bars | input | 1 | 1 selects the colour-bar source |
| col_lo | input | XW | First column of the window |
| col_hi | input | XW | Last column of the window |
| row_lo | input | YW | First line of the window |
| row_hi | input | YW | Last line of the window |
| pix_vld | output | 1 | Pixel valid strobe |
| pix_y | output | DW | Luma |
| pix_cb | output | DW | Blue-difference chroma |
| pix_cr | output | DW | Red-difference chroma |
| line_start | output | 1 | First pixel of a clipped line |
| frame_end | output | 1 | Last pixel of the clipped frame |

## Verification
The line-start and frame-end markers can fall on the same pixel. This happens when the window is one column wide, because on the last line that single pixel is both the first of its line and the last of the frame.

The bench provokes this with col_lo = col_hi = 3, which also places the window on the second pixel of a group. It then expects both markers high on the one pixel of line row_hi, and only `line_start` on that pixel of the earlier lines.

A scoreboard model, built from the byte order and the window rule, checks every emitted pixel against the marker bits the model predicts.

// File: rtl/yc422_window.sv
module yc422_window #(
  parameter int DW = 8,
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cam_byte,
  input  logic          cam_hs,
  input  logic          cam_vs,
  input  logic          src_bars,
  input  logic [XW-1:0] col_lo,
  input  logic [XW-1:0] col_hi,
  input  logic [YW-1:0] row_lo,
  input  logic [YW-1:0] row_hi,
  output logic          pix_vld,
  output logic [DW-1:0] pix_y,
  output logic [DW-1:0] pix_cb,
  output logic [DW-1:0] pix_cr,
  output logic          line_start,
  output logic          frame_end
);
  localparam int CW = XW + 1;

  logic [1:0]    ph;
  logic [XW-1:0] grp;
  logic [YW-1:0] row;
  logic          hs_q;
  logic [DW-1:0] cb_q, y1_q, cr_q;
  logic [DW-1:0] bar_y, bar_cb, bar_cr;

  wire [CW-1:0] col    = {grp, ph[0]};
  wire          emit   = cam_hs && ph[1];
  wire          col_in = (col >= CW'(col_lo)) && (col <= CW'(col_hi));
  wire          row_in = (row >= row_lo) && (row <= row_hi);
  wire          pass   = emit && col_in && row_in;

  wire [DW-1:0] cam_y  = ph[0] ? cam_byte : y1_q;
  wire [DW-1:0] cam_cr = ph[0] ? cr_q : cam_byte;

  function automatic logic [DW-1:0] up(input logic [7:0] v);
    return DW'(v) << (DW - 8);
  endfunction

  always_comb begin
    unique case (col[10:7])
      4'd0, 4'd8: begin bar_y = up(8'd235); bar_cb = up(8'd128); bar_cr = up(8'd128); end
      4'd1, 4'd9: begin bar_y = up(8'd210); bar_cb = up(8'd16);  bar_cr = up(8'd146); end
      4'd3:       begin bar_y = up(8'd145); bar_cb = up(8'd54);  bar_cr = up(8'd34);  end
      4'd4:       begin bar_y = up(8'd106); bar_cb = up(8'd202); bar_cr = up(8'd222); end
      4'd5:       begin bar_y = up(8'd81);  bar_cb = up(8'd90);  bar_cr = up(8'd240); end
      4'd6:       begin bar_y = up(8'd41);  bar_cb = up(8'd240); bar_cr = up(8'd110); end
      4'd7:       begin bar_y = up(8'd16);  bar_cb = up(8'd128); bar_cr = up(8'd128); end
      default:    begin bar_y = up(8'd170); bar_cb = up(8'd166); bar_cr = up(8'd16);  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      grp  <= '0;
      row  <= '0;
      hs_q <= 1'b0;
      cb_q <= '0;
      y1_q <= '0;
      cr_q <= '0;
    end else begin
      hs_q <= cam_hs;
      if (!cam_hs) begin
        ph  <= '0;
        grp <= '0;
      end else begin
        ph <= ph + 2'd1;
        if (ph == 2'd3) grp <= grp + 1'b1;
      end
      if (cam_vs) row <= '0;
      else if (hs_q && !cam_hs) row <= row + 1'b1;
      if (cam_hs && ph == 2'd0) cb_q <= cam_byte;
      if (cam_hs && ph == 2'd1) y1_q <= cam_byte;
      if (cam_hs && ph == 2'd2) cr_q <= cam_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_vld    <= 1'b0;
      pix_y      <= '0;
      pix_cb     <= '0;
      pix_cr     <= '0;
      line_start <= 1'b0;
      frame_end  <= 1'b0;
    end else begin
      pix_vld    <= pass;
      line_start <= pass && (col == CW'(col_lo));
      frame_end  <= pass && (col == CW'(col_hi)) && (row == row_hi);
      if (emit) begin
        pix_y  <= src_bars ? bar_y  : cam_y;
        pix_cb <= src_bars ? bar_cb : cb_q;
        pix_cr <= src_bars ? bar_cr : cam_cr;
      end
    end
  end
endmodule

// File: rtl/yc422_window_chk.sv
module yc422_window_chk (
  input logic clk,
  input logic rst_n,
  input logic cam_hs,
  input logic pix_vld,
  input logic line_start,
  input logic frame_end
);
  always @(posedge clk)
    if (!rst_n)
      a_r1_quiet_in_reset: assert (!pix_vld && !line_start && !frame_end);

  a_r11_blank_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !cam_hs |=> !pix_vld);

  a_r2_pairs_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && $past(pix_vld)) |=> !pix_vld);

  a_r8_start_with_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> pix_vld);

  a_r9_end_with_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> pix_vld);

  a_r9_end_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !pix_vld);
endmodule

bind yc422_window yc422_window_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cam_hs(cam_hs),
  .pix_vld(pix_vld), .line_start(line_start), .frame_end(frame_end)
);

// File: tb/yc422_window_tb_top.sv
module yc422_window_tb_top;
  localparam int XW = 11;
  localparam int YW = 9;

  typedef struct packed {
    logic [7:0] y, cb, cr;
    logic ls, fe;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cam_byte = '0;
  logic cam_hs = 1'b0, cam_vs = 1'b0, src_bars = 1'b0;
  logic [XW-1:0] col_lo = '0, col_hi = '0;
  logic [YW-1:0] row_lo = '0, row_hi = '0;
  logic pix_vld, line_start, frame_end;
  logic [7:0] pix_y, pix_cb, pix_cr;

  int n_chk = 0, n_fail = 0, brow = 0;
  bit done = 0;
  exp_t q[$];
  string tq[$];

  always #2 clk = ~clk;

  yc422_window #(.DW(8), .XW(XW), .YW(YW)) dut_i (
    .clk, .rst_n, .cam_byte, .cam_hs, .cam_vs, .src_bars,
    .col_lo, .col_hi, .row_lo, .row_hi,
    .pix_vld, .pix_y, .pix_cb, .pix_cr, .line_start, .frame_end);

  function automatic logic [23:0] bar(input int col);
    case ((col >> 7) & 15)
      0, 8:    return {8'd235, 8'd128, 8'd128};
      1, 9:    return {8'd210, 8'd16,  8'd146};
      3:       return {8'd145, 8'd54,  8'd34};
      4:       return {8'd106, 8'd202, 8'd222};
      5:       return {8'd81,  8'd90,  8'd240};
      6:       return {8'd41,  8'd240, 8'd110};
      7:       return {8'd16,  8'd128, 8'd128};
      default: return {8'd170, 8'd166, 8'd16};
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  task automatic new_frame();
    @(negedge clk);
    cam_vs = 1'b1; cam_hs = 1'b0;
    repeat (3) @(negedge clk);
    cam_vs = 1'b0;
    repeat (2) @(negedge clk);
    brow = 0;
  endtask

  task automatic send_line(input int nbytes, input string tag);
    logic [7:0] b, ecb, ey1, ecr;
    ecb = '0; ey1 = '0; ecr = '0;
    for (int idx = 0; idx < nbytes; idx++) begin
      int ph, col;
      logic [23:0] t;
      b = 8'((brow * 37 + idx * 11 + 5) & 255);
      cam_byte = b; cam_hs = 1'b1;
      ph = idx % 4;
      col = (idx / 4) * 2 + (ph == 3 ? 1 : 0);
      if (ph == 0) ecb = b;
      if (ph == 1) ey1 = b;
      if (ph == 2) ecr = b;
      if (ph >= 2 && col >= int'(col_lo) && col <= int'(col_hi) &&
          brow >= int'(row_lo) && brow <= int'(row_hi)) begin
        exp_t e;
        t = src_bars ? bar(col) : (ph == 2 ? {ey1, ecb, ecr} : {b, ecb, ecr});
        e.y = t[23:16]; e.cb = t[15:8]; e.cr = t[7:0];
        e.ls = (col == int'(col_lo));
        e.fe = (col == int'(col_hi)) && (brow == int'(row_hi));
        q.push_back(e);
        tq.push_back(tag);
      end
      @(negedge clk);
    end
    cam_hs = 1'b0;
    for (int k = 0; k < 6; k++) begin
      cam_byte = 8'(8'hA5 ^ k);
      @(negedge clk);
    end
    brow++;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pix_vld) begin
        if (q.size() == 0) begin
          check(1'b0, "R11", $sformatf("unexpected pixel y=%0d cb=%0d cr=%0d, expected none",
                                       pix_y, pix_cb, pix_cr));
        end else begin
          exp_t e;
          string tag;
          e = q.pop_front();
          tag = tq.pop_front();
          check({pix_y, pix_cb, pix_cr, line_start, frame_end} == e, tag,
                $sformatf("got y=%0d cb=%0d cr=%0d ls=%0b fe=%0b, expected y=%0d cb=%0d cr=%0d ls=%0b fe=%0b",
                          pix_y, pix_cb, pix_cr, line_start, frame_end,
                          e.y, e.cb, e.cr, e.ls, e.fe));
        end
      end else if (line_start || frame_end) begin
        check(1'b0, "R8/R9", $sformatf("markers ls=%0b fe=%0b without pixel, expected 0",
                                        line_start, frame_end));
      end
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, got hang, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!pix_vld && !line_start && !frame_end, "R1",
          $sformatf("reset vld=%0b ls=%0b fe=%0b, expected 0", pix_vld, line_start, frame_end));
    rst_n = 1'b1;

    // R2 R3 R4 R5: camera path, window columns 2..5, lines 1..2
    src_bars = 1'b0; col_lo = 2; col_hi = 5; row_lo = 1; row_hi = 2;
    new_frame();
    for (int l = 0; l < 4; l++) send_line(16, "R3");

    // R8 R9: one-column window at odd column 3 makes both markers coincide
    col_lo = 3; col_hi = 3; row_lo = 0; row_hi = 2;
    new_frame();
    for (int l = 0; l < 3; l++) send_line(12, "R8");

    // R7: bars over every code of column bits [10:7], one line only
    src_bars = 1'b1; col_lo = 0; col_hi = 11'd2047; row_lo = 0; row_hi = 0;
    new_frame();
    send_line(4096, "R7");
    send_line(40, "R5");

    // R10 R6: bars through a small window across a bar boundary
    col_lo = 125; col_hi = 131; row_lo = 0; row_hi = 1;
    new_frame();
    for (int l = 0; l < 3; l++) send_line(300, "R10");

    // R6 R4: back to camera with the vertical count restarted
    src_bars = 1'b0; col_lo = 0; col_hi = 9; row_lo = 0; row_hi = 0;
    new_frame();
    send_line(24, "R6");

    repeat (8) @(negedge clk);
    check(q.size() == 0, "R2", $sformatf("pending pixels %0d, expected 0", q.size()));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule